// File: doc/BRIEF.md
# Packed SIMD Rounding Average Unit

This unit takes two 128-bit vector operands and treats each one as a set of independent lanes. For every pair of matching lanes it returns the average, rounded half-up. Two opcode fields choose the lane width (8, 16 or 32 bits) and whether the lanes are signed or unsigned. A pipeline inserts the unit as a one-stage execution slot. It presents operands and opcode together with a valid strobe. One clock later it collects the result and a matching valid strobe.

The average is exact. The operand lanes are widened before they are combined, so the carry out of the lane width is never lost. Signed lanes round toward positive infinity at the half point and otherwise follow floor division by two. If the opcode pair matches none of the six defined operations, the unit flags it and returns an all-zero vector.

Top module: `simd_avg_unit`

## Requirements
- R1: Each result lane equals (a + b + 1) >> 1, evaluated exactly, without overflow, on the lane operands. Only the low lane-width bits are returned. Unsigned 8-bit 0xFF with 0xFF gives 0xFF. Unsigned 16-bit 0xFFFF with 0x0001 gives 0x8000.
- R2: Signed operations sign-extend each lane before adding, and the halving is arithmetic. Signed 8-bit 0x80 with 0x80 gives 0x80. Signed 8-bit 0x7F with 0x80 gives 0x00. Signed 32-bit -3 with 0 gives -1.
- R3: The opcode decodes only when grp_i equals 1. In that case sel_i 16, 17 and 18 select unsigned lanes of 8, 16 and 32 bits, and sel_i 20, 21 and 22 select signed lanes of 8, 16 and 32 bits.
- R4: Lane k occupies bits [k*W+W-1 : k*W], with lane 0 at the least significant end. Each lane result depends only on that lane's operands. No carry crosses a lane boundary.
- R5: Any other opcode pair accepted with in_valid_i sets illegal_o and drives res_o to all zeros in the cycle that out_valid_o is high.
- R6: res_o, illegal_o and out_valid_o update on the rising edge that samples in_valid_i high. out_valid_o is high for exactly one cycle per accepted strobe.
- R7: While in_valid_i is low, operand and opcode changes have no effect. res_o holds its last value, and out_valid_o and illegal_o are low on the following cycle.
- R8: A synchronous active-high reset clears out_valid_o, illegal_o and res_o on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operands and opcode are presented this cycle |
| opa_i | input | 128 | First vector operand |
| opb_i | input | 128 | Second vector operand |
| grp_i | input | 6 | Major opcode field |
| sel_i | input | 5 | Minor opcode field |
| out_valid_o | output | 1 | Result is valid this cycle |
| res_o | output | 128 | Lane-wise rounding average |
| illegal_o | output | 1 | The accepted opcode is not one of the six averages |

## Verification
Each result, together with its illegal flag and valid strobe, appears exactly one rising edge after the edge that samples in_valid_i high. A reset takes effect on the first edge at which it is seen. The bench drives every input on a falling edge, lets one rising edge pass, and then compares the outputs at the following falling edge, which is half a cycle away from any update. Checks that something holds or clears (R7, the single-cycle valid pulse of R6, and R8) sample one and two falling edges later.

// File: rtl/simd_avg_pkg.sv
package simd_avg_pkg;

    localparam int GRP_W   = 6;
    localparam int SEL_W   = 5;
    localparam int N_WIDTH = 3;   // lane widths 8, 16, 32

    localparam logic [GRP_W-1:0] GRP_AVG = GRP_W'(1);
    localparam logic [SEL_W-1:0] SEL_U8  = SEL_W'(16);
    localparam logic [SEL_W-1:0] SEL_U16 = SEL_W'(17);
    localparam logic [SEL_W-1:0] SEL_U32 = SEL_W'(18);
    localparam logic [SEL_W-1:0] SEL_S8  = SEL_W'(20);
    localparam logic [SEL_W-1:0] SEL_S16 = SEL_W'(21);
    localparam logic [SEL_W-1:0] SEL_S32 = SEL_W'(22);

    typedef enum logic [1:0] {
        LW_8    = 2'd0,
        LW_16   = 2'd1,
        LW_32   = 2'd2,
        LW_NONE = 2'd3
    } lane_w_e;

    typedef struct packed {
        logic    legal;
        logic    signed_op;
        lane_w_e width;
    } op_dec_t;

endpackage

// File: rtl/simd_avg_decode.sv
module simd_avg_decode
    import simd_avg_pkg::*;
(
    input  logic [GRP_W-1:0] grp_i,
    input  logic [SEL_W-1:0] sel_i,
    output op_dec_t          dec_o
);

    always_comb begin
        dec_o.legal     = 1'b0;
        dec_o.signed_op = 1'b0;
        dec_o.width     = LW_NONE;
        if (grp_i == GRP_AVG) begin
            unique case (sel_i)
                SEL_U8:  begin dec_o.legal = 1'b1; dec_o.width = LW_8;  end
                SEL_U16: begin dec_o.legal = 1'b1; dec_o.width = LW_16; end
                SEL_U32: begin dec_o.legal = 1'b1; dec_o.width = LW_32; end
                SEL_S8:  begin dec_o.legal = 1'b1; dec_o.width = LW_8;  dec_o.signed_op = 1'b1; end
                SEL_S16: begin dec_o.legal = 1'b1; dec_o.width = LW_16; dec_o.signed_op = 1'b1; end
                SEL_S32: begin dec_o.legal = 1'b1; dec_o.width = LW_32; dec_o.signed_op = 1'b1; end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/simd_avg_lanes.sv
// One bank of identical lanes of width LANE_W across a VEC_W-bit vector.
// Average is computed as floor(ea/2) + floor(eb/2) + (a0 | b0), where ea
// and eb are the operands extended by one bit; this equals (a+b+1)>>1 of
// the extended operands exactly and needs only a LANE_W-bit adder.
module simd_avg_lanes #(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    input  logic             signed_i,
    output logic [VEC_W-1:0] avg_o
);

    localparam int N_LANES = VEC_W / LANE_W;
    localparam int EXT_W   = LANE_W + 1;

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        logic [LANE_W-1:0] a_l, b_l;
        logic [EXT_W-1:0]  a_ext, b_ext;
        logic              round_in;

        assign a_l      = a_i[k*LANE_W +: LANE_W];
        assign b_l      = b_i[k*LANE_W +: LANE_W];
        assign a_ext    = {signed_i & a_l[LANE_W-1], a_l};
        assign b_ext    = {signed_i & b_l[LANE_W-1], b_l};
        assign round_in = a_ext[0] | b_ext[0];

        assign avg_o[k*LANE_W +: LANE_W] =
            a_ext[EXT_W-1:1] + b_ext[EXT_W-1:1] + LANE_W'(round_in);
    end

endmodule

// File: rtl/simd_avg_unit.sv
module simd_avg_unit
    import simd_avg_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             in_valid_i,
    input  logic [VEC_W-1:0] opa_i,
    input  logic [VEC_W-1:0] opb_i,
    input  logic [GRP_W-1:0] grp_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             out_valid_o,
    output logic [VEC_W-1:0] res_o,
    output logic             illegal_o
);

    typedef struct packed {
        logic             vld;
        logic             ill;
        logic [VEC_W-1:0] res;
    } out_st_t;

    op_dec_t          dec;
    logic [VEC_W-1:0] avg_w [N_WIDTH];
    out_st_t          st_d, st_q;

    simd_avg_decode u_dec (
        .grp_i (grp_i),
        .sel_i (sel_i),
        .dec_o (dec)
    );

    for (genvar w = 0; w < N_WIDTH; w++) begin : g_width
        simd_avg_lanes #(
            .VEC_W  (VEC_W),
            .LANE_W (8 << w)
        ) u_lanes (
            .a_i      (opa_i),
            .b_i      (opb_i),
            .signed_i (dec.signed_op),
            .avg_o    (avg_w[w])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid_i;
        st_d.ill = 1'b0;
        if (in_valid_i) begin
            st_d.ill = ~dec.legal;
            unique case (dec.width)
                LW_8:    st_d.res = avg_w[0];
                LW_16:   st_d.res = avg_w[1];
                LW_32:   st_d.res = avg_w[2];
                default: st_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.vld;
    assign illegal_o   = st_q.ill;
    assign res_o       = st_q.res;

endmodule

// File: rtl/simd_avg_unit_chk.sv
module simd_avg_unit_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             in_valid_i,
    input logic             out_valid_o,
    input logic [VEC_W-1:0] res_o,
    input logic             illegal_o
);

    logic seen_q = 1'b0;

    always_ff @(posedge clk_i) begin
        if (rst_i) seen_q <= 1'b1;
    end

    // R6: valid strobe follows the accepted input by one edge
    p_valid_follows_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (seen_q && !$past(rst_i)) |-> (out_valid_o == $past(in_valid_i)));

    // R5: illegal result is all zeros
    p_illegal_zero_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        illegal_o |-> (res_o == '0));

    // R5: illegal flag only with a valid result
    p_illegal_valid_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        illegal_o |-> out_valid_o);

    // R7: no strobe means the result holds and no flag is raised
    p_hold_idle_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (seen_q && !$past(rst_i) && !$past(in_valid_i)) |-> ($stable(res_o) && !illegal_o));

    // R8: first cycle after reset is clean
    p_reset_clear_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (seen_q && $past(rst_i)) |-> (!out_valid_o && !illegal_o && res_o == '0));

endmodule

bind simd_avg_unit simd_avg_unit_chk #(.VEC_W(VEC_W)) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .in_valid_i  (in_valid_i),
    .out_valid_o (out_valid_o),
    .res_o       (res_o),
    .illegal_o   (illegal_o)
);

// File: tb/simd_avg_unit_tb_top.sv
module simd_avg_unit_tb_top;

    localparam int VEC_W = 128;

    logic             clk = 1'b0;
    logic             rst_i;
    logic             in_valid_i;
    logic [VEC_W-1:0] opa_i, opb_i;
    logic [5:0]       grp_i;
    logic [4:0]       sel_i;
    logic             out_valid_o;
    logic [VEC_W-1:0] res_o;
    logic             illegal_o;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    simd_avg_unit #(.VEC_W(VEC_W)) dut_i (
        .clk_i       (clk),
        .rst_i       (rst_i),
        .in_valid_i  (in_valid_i),
        .opa_i       (opa_i),
        .opb_i       (opb_i),
        .grp_i       (grp_i),
        .sel_i       (sel_i),
        .out_valid_o (out_valid_o),
        .res_o       (res_o),
        .illegal_o   (illegal_o)
    );

    typedef struct packed {
        logic [5:0]       grp;
        logic [4:0]       sel;
        logic [VEC_W-1:0] a;
        logic [VEC_W-1:0] b;
        logic [VEC_W-1:0] exp;
        logic             ill;
        logic [3:0]       req;
    } vec_t;

    localparam int N_VEC = 12;
    localparam vec_t VECS [N_VEC] = '{
        // R1: unsigned 8-bit 255 with 255 gives 255
        '{6'd1, 5'd16, {16{8'hFF}}, {16{8'hFF}}, {16{8'hFF}}, 1'b0, 4'd1},
        // R2: signed 8-bit -128 with -128 gives -128
        '{6'd1, 5'd20, {16{8'h80}}, {16{8'h80}}, {16{8'h80}}, 1'b0, 4'd2},
        // R2: signed 8-bit 127 with -128 gives 0
        '{6'd1, 5'd20, {16{8'h7F}}, {16{8'h80}}, {VEC_W{1'b0}}, 1'b0, 4'd2},
        // R3: same operands unsigned give 0x80
        '{6'd1, 5'd16, {16{8'h7F}}, {16{8'h80}}, {16{8'h80}}, 1'b0, 4'd3},
        // R1: unsigned 16-bit 0xFFFF with 1 gives 0x8000 (carry kept)
        '{6'd1, 5'd17, {8{16'hFFFF}}, {8{16'h0001}}, {8{16'h8000}}, 1'b0, 4'd1},
        // R3: signed 16-bit -1 with 1 gives 0
        '{6'd1, 5'd21, {8{16'hFFFF}}, {8{16'h0001}}, {VEC_W{1'b0}}, 1'b0, 4'd3},
        // R1: unsigned 32-bit all ones
        '{6'd1, 5'd18, {4{32'hFFFFFFFF}}, {4{32'hFFFFFFFF}}, {4{32'hFFFFFFFF}}, 1'b0, 4'd1},
        // R3: signed 32-bit min with max gives 0
        '{6'd1, 5'd22, {4{32'h80000000}}, {4{32'h7FFFFFFF}}, {VEC_W{1'b0}}, 1'b0, 4'd3},
        // R2: signed 32-bit -3 with 0 gives -1 (arithmetic halving)
        '{6'd1, 5'd22, {4{32'hFFFFFFFD}}, {VEC_W{1'b0}}, {4{32'hFFFFFFFF}}, 1'b0, 4'd2},
        // R4: distinct byte lanes, no cross-lane carry
        '{6'd1, 5'd16, 128'h00112233445566778899AABBCCDDEEFF, {VEC_W{1'b0}},
          128'h0009111A222B333C444D555E666F7780, 1'b0, 4'd4},
        // R5: wrong major field
        '{6'd2, 5'd16, {16{8'h55}}, {16{8'h33}}, {VEC_W{1'b0}}, 1'b1, 4'd5},
        // R5: unused minor value between the two groups
        '{6'd1, 5'd19, {16{8'h55}}, {16{8'h33}}, {VEC_W{1'b0}}, 1'b1, 4'd5}
    };

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_vec(input string tag, input logic [VEC_W-1:0] act,
                             input logic [VEC_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let the capture edge pass, return at the next falling edge.
    task automatic issue(input logic [5:0] g, input logic [4:0] s,
                         input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b);
        grp_i = g; sel_i = s; opa_i = a; opb_i = b; in_valid_i = 1'b1;
        @(negedge clk);
        in_valid_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        rst_i = 1'b1; in_valid_i = 1'b0;
        opa_i = '0; opb_i = '0; grp_i = '0; sel_i = '0;
        repeat (3) @(negedge clk);
        // R8: reset state
        check_bit("R8 reset valid", out_valid_o, 1'b0);
        check_bit("R8 reset illegal", illegal_o, 1'b0);
        check_vec("R8 reset result", res_o, '0);
        rst_i = 1'b0;
        @(negedge clk);

        // Table walk: R1..R5
        for (int i = 0; i < N_VEC; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            issue(VECS[i].grp, VECS[i].sel, VECS[i].a, VECS[i].b);
            check_bit({tag, " valid"}, out_valid_o, 1'b1);
            check_bit({tag, " illegal"}, illegal_o, VECS[i].ill);
            check_vec({tag, " result"}, res_o, VECS[i].exp);
        end

        // R6: single-cycle valid pulse, and a legal op after an illegal one clears the flag
        issue(6'd1, 5'd16, {16{8'h10}}, {16{8'h21}});
        check_bit("R6 legal after illegal", illegal_o, 1'b0);
        check_vec("R6 result", res_o, {16{8'h19}});
        @(negedge clk);
        check_bit("R6 valid drops", out_valid_o, 1'b0);

        // R7: idle inputs change nothing
        grp_i = 6'd3; sel_i = 5'd0; opa_i = {VEC_W{1'b1}}; opb_i = '0;
        @(negedge clk);
        check_vec("R7 hold result", res_o, {16{8'h19}});
        check_bit("R7 no illegal", illegal_o, 1'b0);
        check_bit("R7 no valid", out_valid_o, 1'b0);
        grp_i = 6'd1; sel_i = 5'd22;
        @(negedge clk);
        check_vec("R7 hold result again", res_o, {16{8'h19}});

        // R6: back-to-back strobes, each result one edge later
        grp_i = 6'd1; sel_i = 5'd17; opa_i = {8{16'h0002}}; opb_i = {8{16'h0004}};
        in_valid_i = 1'b1;
        @(negedge clk);
        check_vec("R6 back-to-back first", res_o, {8{16'h0003}});
        sel_i = 5'd20; opa_i = {16{8'hFE}}; opb_i = {16{8'hFF}};
        @(negedge clk);
        check_vec("R6 back-to-back second", res_o, {16{8'hFF}});
        check_bit("R6 back-to-back valid", out_valid_o, 1'b1);
        in_valid_i = 1'b0;

        // R8: reset with a strobe pending
        sel_i = 5'd16; in_valid_i = 1'b1; rst_i = 1'b1;
        @(negedge clk);
        in_valid_i = 1'b0; rst_i = 1'b0;
        check_bit("R8 reset over strobe valid", out_valid_o, 1'b0);
        check_vec("R8 reset over strobe result", res_o, '0);
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule